// File: doc/BRIEF.md
# Serial Wiper Latch Controller

This block is the digital front end of a four-channel programmable resistor. A host drives a three-wire link: a serial clock, a data line and an active-low select. The block shifts 10-bit command words into a shift register. When the select line goes high, it writes the 8-bit value of the word into one of four wiper latches, picked by a 2-bit channel field. The latches drive the wiper codes of the analog section.

All link inputs pass through two-flop synchronizers into a faster system clock. The rising edges of the serial clock and of the select line are turned into single-cycle pulses. An open-drain style serial output lets several devices share one data line in a daisy chain. The output is given as an enable-low signal plus a data value, and the board adds the pull-up. A preset input puts every channel at midscale. A shutdown input turns the serial output off and raises a flag for the analog section.

Top module: `serial_pot_ctrl`

## Requirements
- R1: After system reset, every wiper code is 0x80 and the resolved serial output reads 0.
- R2: While the select line is low, each rising edge of the serial clock shifts the data line into the register. A word is sent most significant bit first, and 10 bits make a full word: bits [9:8] are the channel field and bits [7:0] are the data value.
- R3: A rising edge on the select line writes register bits [7:0] into the latch chosen by bits [9:8]. Field 0 selects wiper_o[7:0], 1 selects [15:8], 2 selects [23:16] and 3 selects [31:24]. The other channels keep their codes.
- R4: Serial clock edges while the select line is high change neither the register nor the serial output. A later select pulse with no clocks reloads the word already held.
- R5: If fewer or more than 10 clocks arrive in one select window, the load uses the 10 bits received most recently, which may include bits left over from earlier windows.
- R6: The serial output presents the bit that entered the register ten shifts earlier. Two chained devices fed 20 bits in one window hold the first 10 bits in the far device and the last 10 bits in the near device.
- R7: Driving preset low sets every wiper to 0x80 and clears the serial output latch, so the output reads 0. This holds even during an open select window. The shift register keeps its contents.
- R8: While shutdown is low, the serial output is released (reads 1) and shdn_o is 1. The wiper codes are kept. After release, the output returns to the latched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk_i | input | 1 | Serial link clock, asynchronous |
| ser_data_i | input | 1 | Serial link data in |
| ser_sel_n_i | input | 1 | Active-low word select |
| preset_n_i | input | 1 | Active-low midscale preset |
| shdn_n_i | input | 1 | Active-low shutdown |
| wiper_o | output | 32 | Four 8-bit wiper codes, channel 0 in the low byte |
| shdn_o | output | 1 | Shutdown flag for the analog section |
| sdo_o | output | 1 | Serial output data value |
| sdo_oe_n_o | output | 1 | Serial output pull-low enable, active low |

## Verification
A corrupted shift register shows up in two places. The serial output goes wrong within one serial clock period. The wiper code loaded at the next select rising edge is also wrong, and the bench checks it a few system cycles later. A bad decode or a stray latch enable corrupts a channel that was not addressed, which the bench sees in the next full comparison of all four wipers. A lost midscale preset or a shutdown release failure is visible at the outputs within a few cycles after the synchronizers. The 20-bit daisy chain also exposes an off-by-one error in the output delay, because the far device then decodes the wrong word.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int unsigned POT_NCH  = 4;
  localparam int unsigned POT_DW   = 8;
  localparam int unsigned POT_AW   = $clog2(POT_NCH);
  localparam int unsigned POT_WORD = POT_AW + POT_DW;
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pot_shift.sv
module pot_shift #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sdo_q, sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (shift_i) begin
      sr_d  = {sr_q[WORD_W-2:0], bit_i};
      sdo_d = sr_q[WORD_W-2];
    end
    if (clr_i) begin
      sdo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/pot_latch_bank.sv
module pot_latch_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     mid_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] code_q, code_d;
    logic              en;

    assign en = load_i && (addr_i == AW'(c));

    always_comb begin
      code_d = code_q;
      if (mid_i)   code_d = MID;
      else if (en) code_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= MID;
      else        code_q <= code_d;
    end

    assign wiper_o[c*DATA_W +: DATA_W] = code_q;
  end
endmodule

// File: rtl/serial_pot_ctrl.sv
module serial_pot_ctrl #(
  parameter int unsigned NUM_CH = pot_pkg::POT_NCH,
  parameter int unsigned DATA_W = pot_pkg::POT_DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk_i,
  input  logic                     ser_data_i,
  input  logic                     ser_sel_n_i,
  input  logic                     preset_n_i,
  input  logic                     shdn_n_i,
  output logic [NUM_CH*DATA_W-1:0] wiper_o,
  output logic                     shdn_o,
  output logic                     sdo_o,
  output logic                     sdo_oe_n_o
);
  localparam int unsigned AW     = $clog2(NUM_CH);
  localparam int unsigned WORD_W = AW + DATA_W;

  logic [4:0]        raw_in, syn_in;
  logic              s_sclk, s_sdi, s_seln, s_preset_n, s_shdn_n;
  logic              sclk_d_q, seln_d_q;
  logic              sclk_rise, cs_rise, shift_en, preset_act, shdn_act;
  logic [WORD_W-1:0] sr_word;
  logic              sdo_q;

  assign raw_in = {ser_clk_i, ser_data_i, ser_sel_n_i, preset_n_i, shdn_n_i};

  pot_sync #(.W(5), .RST_VAL(5'b00111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (syn_in)
  );

  assign {s_sclk, s_sdi, s_seln, s_preset_n, s_shdn_n} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      seln_d_q <= 1'b1;
    end else begin
      sclk_d_q <= s_sclk;
      seln_d_q <= s_seln;
    end
  end

  assign sclk_rise  = s_sclk & ~sclk_d_q;
  assign cs_rise    = s_seln & ~seln_d_q;
  assign shift_en   = sclk_rise & ~s_seln;
  assign preset_act = ~s_preset_n;
  assign shdn_act   = ~s_shdn_n;

  pot_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(shift_en),
    .bit_i  (s_sdi),
    .clr_i  (preset_act),
    .word_o (sr_word),
    .sdo_o  (sdo_q)
  );

  pot_latch_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .AW(AW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cs_rise),
    .addr_i (sr_word[WORD_W-1 -: AW]),
    .data_i (sr_word[DATA_W-1:0]),
    .mid_i  (preset_act),
    .wiper_o(wiper_o)
  );

  assign shdn_o     = shdn_act;
  assign sdo_o      = sdo_q;
  assign sdo_oe_n_o = shdn_act | sdo_q;
endmodule

// File: rtl/pot_ctrl_chk.sv
module pot_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     shift_en,
  input logic                     cs_rise,
  input logic                     preset_act,
  input logic                     shdn_act,
  input logic [WORD_W-1:0]        sr_word,
  input logic                     sdo_q,
  input logic                     sdo_oe_n_o,
  input logic [NUM_CH*DATA_W-1:0] wiper_o
);
  localparam int unsigned AW = WORD_W - DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_word));

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_word[WORD_W-1:1] == $past(sr_word[WORD_W-2:0]));

  assert_sdo_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !preset_act |=> sdo_q == $past(sr_word[WORD_W-2]));

  assert_sdo_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_act |=> !sdo_q);

  assert_wiper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise && !preset_act |=> $stable(wiper_o));

  assert_shdn_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_act |-> sdo_oe_n_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise && !preset_act && (sr_word[WORD_W-1 -: AW] == AW'(c))
      |=> wiper_o[c*DATA_W +: DATA_W] == $past(sr_word[DATA_W-1:0]));

    assert_midscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
      preset_act |=> wiper_o[c*DATA_W +: DATA_W] == MID);
  end
endmodule

bind serial_pot_ctrl pot_ctrl_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .cs_rise   (cs_rise),
  .preset_act(preset_act),
  .shdn_act  (shdn_act),
  .sr_word   (sr_word),
  .sdo_q     (sdo_q),
  .sdo_oe_n_o(sdo_oe_n_o),
  .wiper_o   (wiper_o)
);

// File: tb/serial_pot_ctrl_tb.sv
module serial_pot_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, sclk, sdi, seln, preset_n, shdn_n;
  logic [31:0] wip_a, wip_b;
  logic shdn_a, shdn_b, sdo_a, sdo_b, oe_a, oe_b;
  logic line_a, line_b;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [9:0] ma_sr, mb_sr;
  logic       ma_sdo, mb_sdo, m_shdn;
  logic [7:0] ma_w [4];
  logic [7:0] mb_w [4];

  always #2.5 clk = ~clk;

  assign line_a = oe_a ? 1'b1 : sdo_a;
  assign line_b = oe_b ? 1'b1 : sdo_b;

  serial_pot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdi),
    .ser_sel_n_i(seln), .preset_n_i(preset_n), .shdn_n_i(shdn_n),
    .wiper_o(wip_a), .shdn_o(shdn_a), .sdo_o(sdo_a), .sdo_oe_n_o(oe_a));

  serial_pot_ctrl u_dut_far (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(line_a),
    .ser_sel_n_i(seln), .preset_n_i(preset_n), .shdn_n_i(shdn_n),
    .wiper_o(wip_b), .shdn_o(shdn_b), .sdo_o(sdo_b), .sdo_oe_n_o(oe_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_line(input logic q);
    return m_shdn ? 1'b1 : q;
  endfunction

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(wip_a[c*8 +: 8] == ma_w[c], req, wip_a[c*8 +: 8], ma_w[c]);
      chk(wip_b[c*8 +: 8] == mb_w[c], req, wip_b[c*8 +: 8], mb_w[c]);
    end
    chk(line_a == exp_line(ma_sdo), req, line_a, exp_line(ma_sdo));
    chk(line_b == exp_line(mb_sdo), req, line_b, exp_line(mb_sdo));
  endtask

  task automatic ser_bit(input logic b, input bit sel_low);
    logic a_old;
    sdi = b;
    wait_sys(8);
    sclk = 1'b1;
    if (sel_low) begin
      a_old  = exp_line(ma_sdo);
      mb_sdo = mb_sr[8];
      mb_sr  = {mb_sr[8:0], a_old};
      ma_sdo = ma_sr[8];
      ma_sr  = {ma_sr[8:0], b};
    end
    wait_sys(8);
    sclk = 1'b0;
  endtask

  task automatic open_sel();
    seln = 1'b0;
    wait_sys(8);
  endtask

  task automatic close_sel();
    wait_sys(8);
    seln = 1'b1;
    ma_w[ma_sr[9:8]] = ma_sr[7:0];
    mb_w[mb_sr[9:8]] = mb_sr[7:0];
    wait_sys(12);
  endtask

  task automatic frame(input logic [31:0] v, input int n, input string req);
    open_sel();
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i], 1'b1);
    close_sel();
    check_all(req);
  endtask

  task automatic do_preset();
    preset_n = 1'b0;
    for (int c = 0; c < 4; c++) begin ma_w[c] = 8'h80; mb_w[c] = 8'h80; end
    ma_sdo = 1'b0;
    mb_sdo = 1'b0;
    wait_sys(8);
    check_all("R7 preset midscale");
    preset_n = 1'b1;
    wait_sys(6);
  endtask

  initial begin
    logic [7:0] line_before;
    void'($urandom(32'd4711));
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; seln = 1'b1;
    preset_n = 1'b1; shdn_n = 1'b1; m_shdn = 1'b0;
    ma_sr = '0; mb_sr = '0; ma_sdo = 1'b0; mb_sdo = 1'b0;
    for (int c = 0; c < 4; c++) begin ma_w[c] = 8'h80; mb_w[c] = 8'h80; end
    wait_sys(5);
    rst_n = 1'b1;
    wait_sys(5);
    check_all("R1 reset state");

    // R3: one directed write per channel, R2 bit order
    frame({22'd0, 2'b00, 8'h3C}, 10, "R3 R2 channel 0");
    frame({22'd0, 2'b01, 8'hA5}, 10, "R3 channel 1");
    frame({22'd0, 2'b10, 8'h01}, 10, "R3 channel 2");
    frame({22'd0, 2'b11, 8'hFE}, 10, "R3 channel 3");

    // R6: 20-bit daisy chain, far word first
    frame({12'd0, 2'b10, 8'h5A, 2'b01, 8'hC3}, 20, "R6 chain");
    chk(wip_b[23:16] == 8'h5A, "R6 far device word", wip_b[23:16], 8'h5A);
    chk(wip_a[15:8] == 8'hC3, "R6 near device word", wip_a[15:8], 8'hC3);

    // R5: short and long frames
    frame(32'h2, 3, "R5 short frame");
    frame(32'hABCD, 13, "R5 long frame");

    // R4: clocks with select high, then a bare select pulse
    line_before = {7'd0, line_a};
    for (int i = 0; i < 5; i++) ser_bit(1'($urandom), 1'b0);
    chk(line_a == line_before[0], "R4 idle clocks sdo", line_a, line_before[0]);
    check_all("R4 idle clocks state");
    frame(32'h0, 0, "R4 bare select reload");

    // random frames
    for (int k = 0; k < 24; k++) begin
      frame($urandom, 1 + ($urandom % 20), "R2 R3 R5 R6 random");
    end

    // R7: preset in the middle of an open window
    open_sel();
    for (int i = 0; i < 5; i++) ser_bit(1'($urandom), 1'b1);
    do_preset();
    for (int i = 0; i < 5; i++) ser_bit(1'($urandom), 1'b1);
    close_sel();
    check_all("R7 load after preset");

    // R8: shutdown with output latch cleared
    do_preset();
    shdn_n = 1'b0;
    m_shdn = 1'b1;
    wait_sys(8);
    chk(line_a == 1'b1, "R8 sdo released", line_a, 1);
    chk(shdn_a == 1'b1, "R8 flag", shdn_a, 1);
    check_all("R8 latches kept");
    shdn_n = 1'b1;
    m_shdn = 1'b0;
    wait_sys(8);
    chk(shdn_a == 1'b0, "R8 flag release", shdn_a, 0);
    chk(line_a == 1'b0, "R8 sdo restored", line_a, 0);
    frame({22'd0, 2'b11, 8'h42}, 10, "R8 after shutdown");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule